// File: doc/BRIEF.md
# Data Strobe Serial Receiver

This block receives a two-wire serial link made of one data wire and one strobe wire. No clock travels with the link. For each bit, either the data wire takes the new bit value, or, when the bit repeats the previous one, the strobe wire toggles. The bit timing therefore comes from the exclusive-OR of the two wires. That recovered clock runs at half the bit rate, and both of its edges mark a bit.

The receiver samples both wires with a fast local clock that must run at least four times the bit rate. Each wire passes through its own synchroniser. The block then looks for any change in the XOR of the two synchronised wires. Each change produces one recovered bit, whose value is the synchronised data level at that moment. Recovered bits come out one at a time with a one-cycle valid pulse. They also collect in a shift register, and a byte-ready pulse marks every eighth bit.

If both wires change in the same sample, the link has broken its one-wire-per-bit rule. The block then flags a line error and drops that bit.

Top module: `ds_link_rx`

## Requirements
- R1: While reset is active, and in the first cycles after it is released, `rx_bit_vld`, `rx_byte_rdy` and `line_err` are 0 and `rx_shift` is all zeros.
- R2: Both wires are synchronised through two flops. With the default parameters, a single change on one wire that is driven between clock edges gives an `rx_bit_vld` pulse after the third rising clock edge that follows the change.
- R3: Every change of data XOR strobe yields exactly one recovered bit. This holds for rising and for falling transitions of the XOR.
- R4: The recovered bit equals the synchronised data level after the change. A change on the strobe wire alone therefore repeats the current data level.
- R5: `rx_bit_vld` is high for exactly one clock per recovered bit.
- R6: When both wires change in the same sample, `line_err` pulses for one clock. No bit is emitted, and neither `rx_shift` nor the bit count changes.
- R7: Each recovered bit enters `rx_shift` at bit 0 and moves older bits toward bit 7. `rx_shift` updates in the clock after the bit's `rx_bit_vld` pulse.
- R8: `rx_byte_rdy` pulses for one clock after every eighth recovered bit counted from reset. In that clock, `rx_shift` holds those eight bits, with the earliest in bit 7.
- R9: With a system clock of exactly four cycles per bit, every bit of a continuous stream is recovered with no loss.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| link_d | input | 1 | Serial data wire, asynchronous to clk |
| link_s | input | 1 | Serial strobe wire, asynchronous to clk |
| rx_bit | output | 1 | Most recently recovered bit value |
| rx_bit_vld | output | 1 | One-cycle pulse when a new bit is recovered |
| rx_shift | output | 8 | Recent recovered bits, newest in bit 0 |
| rx_byte_rdy | output | 1 | One-cycle pulse every eighth recovered bit |
| line_err | output | 1 | One-cycle pulse when both wires changed in one sample |

## Verification
Several properties are checked on every cycle. A valid pulse never coincides with a line error. Each valid pulse follows an observed XOR change. A line error leaves the shift register untouched. The newest shift bit matches the bit that was just emitted. A byte-ready pulse always follows a valid pulse and never repeats in the next cycle.

Some behaviours can only be shown by the bench's scenarios. These are the exact three-cycle latency, the bit values for data-only and strobe-only transitions, and the shift contents at a partial byte. The bench also sends all 256 byte values at the minimum four-cycle bit period and checks that every byte arrives whole and in order.

// File: rtl/ds_rx_pkg.sv
package ds_rx_pkg;
  localparam int unsigned DS_SYNC_STAGES = 2;
  localparam int unsigned DS_SHIFT_W     = 8;

  typedef struct packed {
    logic d;
    logic s;
  } ds_pair_t;
endpackage

// File: rtl/ds_sync.sv
module ds_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned W      = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      logic [W-1:0] stg_n;
      if (g == 0) begin : g_first
        always_comb stg_n = din;
      end else begin : g_rest
        always_comb stg_n = stg[g-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[g] <= '0;
        else        stg[g] <= stg_n;
      end
    end
  endgenerate

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/ds_edge_det.sv
module ds_edge_det
  import ds_rx_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  ds_pair_t ln,
  output logic     bit_o,
  output logic     bit_vld_o,
  output logic     err_o
);
  logic d_q, s_q, bit_q, vld_q, err_q;
  logic d_chg, s_chg, vld_n, err_n, bit_n;

  // next-state
  always_comb begin
    d_chg = ln.d ^ d_q;
    s_chg = ln.s ^ s_q;
    vld_n = d_chg ^ s_chg;   // exactly one wire moved: XOR clock edge
    err_n = d_chg & s_chg;   // both moved: protocol violation
    bit_n = vld_n ? ln.d : bit_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d_q   <= 1'b0;
      s_q   <= 1'b0;
      bit_q <= 1'b0;
      vld_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      d_q   <= ln.d;
      s_q   <= ln.s;
      bit_q <= bit_n;
      vld_q <= vld_n;
      err_q <= err_n;
    end
  end

  assign bit_o     = bit_q;
  assign bit_vld_o = vld_q;
  assign err_o     = err_q;

  AST_VLD_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(vld_q && err_q)); // R6

  AST_VLD_FROM_XOR: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |-> $past((ln.d ^ ln.s) != (d_q ^ s_q))); // R3
endmodule

// File: rtl/ds_deser.sv
module ds_deser #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bit_i,
  input  logic         vld_i,
  output logic [W-1:0] shift_o,
  output logic         rdy_o
);
  localparam int unsigned CNT_W = (W > 1) ? $clog2(W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

  logic [W-1:0]     sh_q, sh_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             rdy_q, rdy_n;

  // next-state
  always_comb begin
    sh_n  = sh_q;
    cnt_n = cnt_q;
    rdy_n = 1'b0;
    if (vld_i) begin
      if (W > 1) sh_n = {sh_q[W-2:0], bit_i};
      else       sh_n = bit_i;
      if (cnt_q == LAST) begin
        cnt_n = '0;
        rdy_n = 1'b1;
      end else begin
        cnt_n = cnt_q + 1'b1;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
      rdy_q <= 1'b0;
    end else begin
      sh_q  <= sh_n;
      cnt_q <= cnt_n;
      rdy_q <= rdy_n;
    end
  end

  assign shift_o = sh_q;
  assign rdy_o   = rdy_q;

  AST_RDY_AFTER_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_q |-> $past(vld_i)); // R8

  AST_RDY_NO_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_q |=> !rdy_q); // R8

  AST_NEWEST_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    $past(vld_i) |-> (sh_q[0] == $past(bit_i))); // R7
endmodule

// File: rtl/ds_link_rx.sv
module ds_link_rx
  import ds_rx_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = DS_SYNC_STAGES,
  parameter int unsigned SHIFT_W     = DS_SHIFT_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               link_d,
  input  logic               link_s,
  output logic               rx_bit,
  output logic               rx_bit_vld,
  output logic [SHIFT_W-1:0] rx_shift,
  output logic               rx_byte_rdy,
  output logic               line_err
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_ff;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_ff <= 2'b00;
    else        rst_ff <= {rst_ff[0], 1'b1};
  end
  assign rst_i = rst_ff[1];

  logic [1:0] raw_pair, sync_pair;
  ds_pair_t   ln;
  logic       bit_w, vld_w;

  assign raw_pair = {link_d, link_s};

  ds_sync #(.STAGES(SYNC_STAGES), .W(2)) i_sync (
    .clk  (clk),
    .rst_n(rst_i),
    .din  (raw_pair),
    .dout (sync_pair)
  );

  assign ln = ds_pair_t'(sync_pair);

  ds_edge_det i_edge (
    .clk      (clk),
    .rst_n    (rst_i),
    .ln       (ln),
    .bit_o    (bit_w),
    .bit_vld_o(vld_w),
    .err_o    (line_err)
  );

  ds_deser #(.W(SHIFT_W)) i_deser (
    .clk    (clk),
    .rst_n  (rst_i),
    .bit_i  (bit_w),
    .vld_i  (vld_w),
    .shift_o(rx_shift),
    .rdy_o  (rx_byte_rdy)
  );

  assign rx_bit     = bit_w;
  assign rx_bit_vld = vld_w;

  AST_ERR_NO_SHIFT: assert property (@(posedge clk) disable iff (!rst_i)
    line_err |=> $stable(rx_shift)); // R6

  AST_RST_QUIET: assert property (@(posedge clk)
    !rst_i |-> (!rx_bit_vld && !rx_byte_rdy && !line_err)); // R1
endmodule

// File: tb/test_ds_link_rx.sv
module test_ds_link_rx;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       link_d, link_s;
  logic       rx_bit, rx_bit_vld, rx_byte_rdy, line_err;
  logic [7:0] rx_shift;

  always #10 clk = ~clk;

  ds_link_rx i_ds_link_rx (
    .clk(clk), .rst_n(rst_n), .link_d(link_d), .link_s(link_s),
    .rx_bit(rx_bit), .rx_bit_vld(rx_bit_vld), .rx_shift(rx_shift),
    .rx_byte_rdy(rx_byte_rdy), .line_err(line_err)
  );

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit done  = 0;

  // monitor
  int       nbits, nbytes, nerr, wide_vld;
  bit       got_bits  [0:4095];
  int       bit_cyc   [0:4095];
  bit [7:0] got_bytes [0:511];
  bit       prev_vld;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rx_bit_vld) begin
      if (nbits < 4096) begin
        got_bits[nbits] = rx_bit;
        bit_cyc[nbits]  = cyc;
      end
      nbits = nbits + 1;
      if (prev_vld) wide_vld = wide_vld + 1;
    end
    prev_vld = rx_bit_vld;
    if (rx_byte_rdy) begin
      if (nbytes < 512) got_bytes[nbytes] = rx_shift;
      nbytes = nbytes + 1;
    end
    if (line_err) nerr = nerr + 1;
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    link_d = 1'b0;
    link_s = 1'b0;
    rst_n  = 1'b0;
    repeat (3) @(negedge clk);
    nbits = 0; nbytes = 0; nerr = 0; wide_vld = 0; prev_vld = 1'b0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // encode one bit: data wire takes the bit, else strobe toggles
  task automatic send_bit(input bit b, input int hold);
    if (b != link_d) link_d = b;
    else             link_s = ~link_s;
    repeat (hold) @(negedge clk);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int c0;
    logic [7:0] sh_before;
    rst_n = 1'b0;
    link_d = 1'b0;
    link_s = 1'b0;
    @(negedge clk);
    // R1: state while in reset
    check("R1 vld in reset", int'(rx_bit_vld), 0);
    check("R1 rdy in reset", int'(rx_byte_rdy), 0);
    check("R1 err in reset", int'(line_err), 0);
    check("R1 shift in reset", int'(rx_shift), 0);
    do_reset();
    check("R1 shift after release", int'(rx_shift), 0);
    check("R1 no bits after release", nbits, 0);

    // R2/R4: data rises -> bit 1, latency 3 edges
    c0 = cyc;
    send_bit(1'b1, 6);
    check("R2 bit count", nbits, 1);
    check("R2 latency", bit_cyc[0] - c0, 3);
    check("R4 data-edge value", int'(got_bits[0]), 1);
    // R3/R4: strobe-only change, XOR falls, repeats 1
    send_bit(1'b1, 6);
    check("R3 falling XOR gives bit", nbits, 2);
    check("R4 strobe-edge value", int'(got_bits[1]), 1);
    send_bit(1'b0, 6);
    check("R4 data falls value", int'(got_bits[2]), 0);
    // R7: newest in bit0
    check("R7 partial shift", int'(rx_shift), 8'b0000_0110);
    check("R8 no early rdy", nbytes, 0);

    // R6: both wires together
    sh_before = rx_shift;
    link_d = ~link_d;
    link_s = ~link_s;
    repeat (6) @(negedge clk);
    check("R6 err pulse count", nerr, 1);
    check("R6 no bit on err", nbits, 3);
    check("R6 shift unchanged", int'(rx_shift), int'(sh_before));
    // count untouched: five more bits complete the byte
    for (int k = 0; k < 5; k++) send_bit(k[0], 4);
    repeat (6) @(negedge clk);
    check("R6 count unaffected rdy", nbytes, 1);
    check("R8 byte after err", int'(got_bytes[0]), 8'b1100_1010);

    // R9/R8: all byte values at 4 cycles per bit
    do_reset();
    for (int v = 0; v < 256; v++)
      for (int i = 7; i >= 0; i--) send_bit(v[i], 4);
    repeat (8) @(negedge clk);
    check("R9 bit count", nbits, 2048);
    check("R8 byte count", nbytes, 256);
    check("R5 vld width", wide_vld, 0);
    check("R6 no spurious err", nerr, 0);
    for (int v = 0; v < 256; v++)
      check($sformatf("R8 byte %0d", v), int'(got_bytes[v]), v);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule